// File: doc/BRIEF.md
# Secure Lockdown Register Bank

This block stores the way-lockdown masks of a set-associative cache of up to 16 ways. Each 3-bit requester ID owns two masks, one for data allocations and one for instruction allocations, and every mask bit stops one way from receiving new lines. The allocation logic supplies the requester ID, taken from bits [7:5] of the requester's user sideband, and an instruction/data flag. The block returns the matching mask at once, with no clock delay.

Software reaches the masks through a simple register port. Each request carries a security attribute. Secure requests may always change a mask. Non-secure requests may change one only when a non-secure enable bit is set, and only a secure request can set that bit. A refused write leaves all state unchanged and answers with a decode error. Every request gets exactly one response, in the cycle after it is accepted.

Top module: `lockdown_regbank`

## Requirements
- R1: After reset, every mask is 0 (no way locked), the non-secure enable bit is 0, `alloc_mask_o` is 0 and `rsp_valid_o` is 0.
- R2: The data mask of requester n is at offset 0x900+8n and its instruction mask is at 0x904+8n, for n = 0..7. Address bits [1:0] are ignored. A secure write updates the mask and answers OKAY (`rsp_resp_o` = 2'b00), and a later read returns the new value.
- R3: A non-secure write to a mask while the enable bit is 0 answers DECERR (`rsp_resp_o` = 2'b11) with `rsp_rdata_o` = 0, and leaves the mask unchanged.
- R4: A non-secure write to a mask while the enable bit is 1 updates it and answers OKAY.
- R5: Reads are allowed for both security states and answer OKAY.
- R6: Mask bit i stands for way i. Bits [31:16] always read 0. With `NUM_WAYS` = 8, bits [15:8] are not stored, read 0 and are 0 on `alloc_mask_o`.
- R7: `alloc_mask_o` shows, in the same cycle, the data mask (`alloc_instr_i` = 0) or the instruction mask (`alloc_instr_i` = 1) of the requester given by `alloc_master_i`.
- R8: The control word at offset 0x9F0 holds the non-secure enable bit in bit 0 and can be read by both security states. Only a secure write changes it. A non-secure write to it answers DECERR and changes nothing.
- R9: Any other offset reads 0 with OKAY. Writes to such offsets answer OKAY and have no effect.
- R10: With `BY_MASTER` = 0, only the requester-0 pair exists. `alloc_mask_o` ignores `alloc_master_i`, and the offsets of requesters 1..7 act as in R9.
- R11: `rsp_valid_o` is 1 in the cycle after each cycle with `req_valid_i` = 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_nonsec_i | input | 1 | 1 = non-secure request |
| req_addr_i | input | 12 | Byte offset in the controller register space |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_resp_o | output | 2 | 2'b00 OKAY, 2'b11 DECERR |
| rsp_rdata_o | output | 32 | Read data, 0 for writes and errors |
| alloc_master_i | input | 3 | Requester ID of the allocating access |
| alloc_instr_i | input | 1 | 1 = instruction allocation |
| alloc_mask_o | output | 16 | Locked-way mask for the allocation |

## Verification
The bench makes non-secure writes to masks and to the control word, both before and after the enable bit is set and again after it is cleared. A design that checks permission wrongly would accept a write that should fail, or refuse one that should succeed, and the read-back would show it. Upper data bits are written as ones, and a second instance with 8 ways and a single pair must drop bits [15:8] and ignore the requester ID. Unmapped offsets and the offsets of requesters that do not exist must read as zero after a write. Reset in the middle of the run must clear the masks, which a design with a missing reset term would keep.

// File: rtl/lkdn_pkg.sv
package lkdn_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned MASK_W   = 16;
  localparam logic [ADDR_W-1:0] LOCK_BASE = 12'h900;
  localparam logic [ADDR_W-1:0] CTRL_OFS  = 12'h9F0;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_DECERR = 2'b11
  } resp_e;
endpackage

// File: rtl/lkdn_decode.sv
module lkdn_decode
  import lkdn_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 8,
  parameter bit          BY_MASTER   = 1'b1,
  localparam int unsigned IDX_W      = $clog2(NUM_MASTERS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              lock_hit_o,
  output logic              ctrl_hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              is_instr_o
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(8 * NUM_MASTERS);

  logic [ADDR_W-1:0] word_addr;
  logic [ADDR_W-1:0] off;
  logic              in_range;

  assign word_addr  = {addr_i[ADDR_W-1:2], 2'b00};
  assign off        = word_addr - LOCK_BASE;
  assign in_range   = (word_addr >= LOCK_BASE) && (off < SPAN);
  assign idx_o      = off[3 +: IDX_W];
  assign is_instr_o = off[2];
  assign ctrl_hit_o = (word_addr == CTRL_OFS);

  // without per-master lockdown only entry 0 is decoded
  generate
    if (BY_MASTER) begin : g_all
      assign lock_hit_o = in_range;
    end else begin : g_one
      assign lock_hit_o = in_range && (idx_o == '0);
    end
  endgenerate
endmodule

// File: rtl/lkdn_mask_reg.sv
module lkdn_mask_reg #(
  parameter int unsigned WAYS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [WAYS-1:0] wdata_i,
  output logic [WAYS-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= wdata_i;
  end

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q_o)); // R3
endmodule

// File: rtl/lkdn_mask_sel.sv
module lkdn_mask_sel #(
  parameter int unsigned NUM_MASTERS = 8,
  parameter int unsigned WAYS        = 16,
  parameter bit          BY_MASTER   = 1'b1,
  localparam int unsigned IDX_W      = $clog2(NUM_MASTERS)
) (
  input  logic [NUM_MASTERS-1:0][WAYS-1:0] data_q_i,
  input  logic [NUM_MASTERS-1:0][WAYS-1:0] instr_q_i,
  input  logic [IDX_W-1:0]                 master_i,
  input  logic                             instr_i,
  output logic [WAYS-1:0]                  mask_o
);
  logic [IDX_W-1:0] sel;

  generate
    if (BY_MASTER) begin : g_sel_id
      assign sel = master_i;
    end else begin : g_sel_zero
      assign sel = '0;
    end
  endgenerate

  assign mask_o = instr_i ? instr_q_i[sel] : data_q_i[sel];
endmodule

// File: rtl/lockdown_regbank.sv
module lockdown_regbank
  import lkdn_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 8,
  parameter int unsigned NUM_WAYS    = 16,
  parameter bit          BY_MASTER   = 1'b1,
  localparam int unsigned IDX_W      = $clog2(NUM_MASTERS),
  localparam int unsigned ENTRIES    = BY_MASTER ? NUM_MASTERS : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_nonsec_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_resp_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [IDX_W-1:0]  alloc_master_i,
  input  logic              alloc_instr_i,
  output logic [MASK_W-1:0] alloc_mask_o
);
  logic                                lock_hit, ctrl_hit, is_instr;
  logic [IDX_W-1:0]                    idx;
  logic [NUM_MASTERS-1:0][NUM_WAYS-1:0] data_q, instr_q;
  logic [NUM_WAYS-1:0]                 sel_mask;
  logic                                ns_en_q;
  logic                                wr_ok, wr_req, lock_we, ctrl_we, deny;
  logic [DATA_W-1:0]                   rd_data;
  resp_e                               resp_d;

  lkdn_decode #(.NUM_MASTERS(NUM_MASTERS), .BY_MASTER(BY_MASTER)) u_dec (
    .addr_i    (req_addr_i),
    .lock_hit_o(lock_hit),
    .ctrl_hit_o(ctrl_hit),
    .idx_o     (idx),
    .is_instr_o(is_instr)
  );

  // permission: secure always, non-secure only once enabled
  assign wr_ok   = !req_nonsec_i || ns_en_q;
  assign wr_req  = req_valid_i && req_write_i;
  assign lock_we = wr_req && lock_hit && wr_ok;
  assign ctrl_we = wr_req && ctrl_hit && !req_nonsec_i;
  assign deny    = wr_req && ((lock_hit && !wr_ok) || (ctrl_hit && req_nonsec_i));

  generate
    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_ent
      if (g < ENTRIES) begin : g_impl
        logic [IDX_W-1:0] my_idx;
        assign my_idx = IDX_W'(g);
        lkdn_mask_reg #(.WAYS(NUM_WAYS)) u_data (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .wr_en_i(lock_we && !is_instr && (idx == my_idx)),
          .wdata_i(req_wdata_i[NUM_WAYS-1:0]),
          .q_o    (data_q[g])
        );
        lkdn_mask_reg #(.WAYS(NUM_WAYS)) u_instr (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .wr_en_i(lock_we && is_instr && (idx == my_idx)),
          .wdata_i(req_wdata_i[NUM_WAYS-1:0]),
          .q_o    (instr_q[g])
        );
      end else begin : g_absent
        assign data_q[g]  = '0;
        assign instr_q[g] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ns_en_q <= 1'b0;
    else if (ctrl_we) ns_en_q <= req_wdata_i[0];
  end

  always_comb begin
    rd_data = '0;
    if (lock_hit)      rd_data = DATA_W'(is_instr ? instr_q[idx] : data_q[idx]);
    else if (ctrl_hit) rd_data = DATA_W'(ns_en_q);
    resp_d = deny ? RESP_DECERR : RESP_OKAY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_resp_o  <= RESP_OKAY;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_resp_o  <= resp_d;
        rsp_rdata_o <= req_write_i ? '0 : rd_data;
      end
    end
  end

  lkdn_mask_sel #(.NUM_MASTERS(NUM_MASTERS), .WAYS(NUM_WAYS), .BY_MASTER(BY_MASTER)) u_sel (
    .data_q_i (data_q),
    .instr_q_i(instr_q),
    .master_i (alloc_master_i),
    .instr_i  (alloc_instr_i),
    .mask_o   (sel_mask)
  );

  assign alloc_mask_o = MASK_W'(sel_mask);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R11
  AST_NS_BLOCKED_DECERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && req_nonsec_i && !ns_en_q && lock_hit) |=> (rsp_resp_o == RESP_DECERR)); // R3
  AST_DECERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_resp_o == RESP_DECERR) |-> (rsp_rdata_o == '0)); // R3
  AST_NS_WRITE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && req_nonsec_i && ns_en_q && lock_hit) |=> (rsp_resp_o == RESP_OKAY)); // R4
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_rdata_o[DATA_W-1:NUM_WAYS] == '0)); // R6
  AST_CTRL_NS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && ctrl_hit && req_nonsec_i) |=> $stable(ns_en_q)); // R8
endmodule

// File: tb/sim_lockdown_regbank.sv
module sim_lockdown_regbank;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic        wr;
    logic        ns;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [1:0]  resp;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 12'h900, 32'hFFFF_1234, 2'b00, 32'h0},    // R2 secure write data0, upper ones
    '{1'b0, 1'b0, 12'h900, 32'h0,         2'b00, 32'h1234}, // R2 R6 read back
    '{1'b1, 1'b0, 12'h93C, 32'h0000_8001, 2'b00, 32'h0},    // R2 instr7
    '{1'b0, 1'b1, 12'h93E, 32'h0,         2'b00, 32'h8001}, // R5 ns read, low bits ignored
    '{1'b1, 1'b1, 12'h900, 32'h0000_5555, 2'b11, 32'h0},    // R3 ns write blocked
    '{1'b0, 1'b1, 12'h900, 32'h0,         2'b00, 32'h1234}, // R3 unchanged
    '{1'b1, 1'b1, 12'h9F0, 32'h1,         2'b11, 32'h0},    // R8 ns ctrl write refused
    '{1'b0, 1'b0, 12'h9F0, 32'h0,         2'b00, 32'h0},    // R8 still clear
    '{1'b1, 1'b0, 12'h9F0, 32'h1,         2'b00, 32'h0},    // R8 secure enable
    '{1'b0, 1'b1, 12'h9F0, 32'h0,         2'b00, 32'h1},    // R8 ns reads enable
    '{1'b1, 1'b1, 12'h914, 32'h0000_00A5, 2'b00, 32'h0},    // R4 ns write instr2
    '{1'b0, 1'b0, 12'h914, 32'h0,         2'b00, 32'hA5},   // R4 read back
    '{1'b0, 1'b0, 12'h944, 32'h0,         2'b00, 32'h0},    // R9 unmapped read
    '{1'b1, 1'b1, 12'h944, 32'hFFFF_FFFF, 2'b00, 32'h0},    // R9 unmapped write
    '{1'b0, 1'b0, 12'h944, 32'h0,         2'b00, 32'h0},    // R9 no effect
    '{1'b0, 1'b1, 12'h000, 32'h0,         2'b00, 32'h0},    // R9 outside window
    '{1'b1, 1'b1, 12'h900, 32'h0000_00F0, 2'b00, 32'h0},    // R4 ns write data0
    '{1'b0, 1'b1, 12'h900, 32'h0,         2'b00, 32'hF0},   // R4 read back
    '{1'b1, 1'b0, 12'h9F0, 32'h0,         2'b00, 32'h0},    // R8 secure disable
    '{1'b1, 1'b1, 12'h904, 32'h0000_0001, 2'b11, 32'h0},    // R3 blocked again
    '{1'b0, 1'b0, 12'h904, 32'h0,         2'b00, 32'h0}     // R3 unchanged
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ns = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  a_master = '0;
  logic        a_instr = 1'b0;
  logic        v0, v1;
  logic [1:0]  r0, r1;
  logic [31:0] d0, d1;
  logic [15:0] m0, m1;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockdown_regbank u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_nonsec_i(req_ns), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(v0), .rsp_resp_o(r0), .rsp_rdata_o(d0),
    .alloc_master_i(a_master), .alloc_instr_i(a_instr), .alloc_mask_o(m0)
  );

  lockdown_regbank #(.NUM_WAYS(8), .BY_MASTER(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_nonsec_i(req_ns), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(v1), .rsp_resp_o(r1), .rsp_rdata_o(d1),
    .alloc_master_i(a_master), .alloc_instr_i(a_instr), .alloc_mask_o(m1)
  );

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // drive at negedge, response registered at next posedge, sample at following negedge
  task automatic bus(input logic wr, input logic ns, input logic [11:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_ns = ns; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic alloc(input logic [2:0] m, input logic ins);
    @(negedge clk);
    a_master = m; a_instr = ins;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", 32'(v0), 32'h0);
    for (int m = 0; m < 8; m++) begin
      alloc(3'(m), m[0]);
      check("R1 alloc mask after reset", 32'(m0), 32'h0);
    end
    bus(1'b0, 1'b0, 12'h9F0, 32'h0);
    check("R1 ns enable after reset", d0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].wr, VECS[i].ns, VECS[i].addr, VECS[i].wd);
      check($sformatf("vec %0d valid (R11)", i), 32'(v0), 32'h1);
      check($sformatf("vec %0d resp (R2-family)", i), 32'(r0), 32'(VECS[i].resp));
      check($sformatf("vec %0d rdata (R2-family)", i), d0, VECS[i].rd);
    end

    // R11: valid drops one cycle after a lone request
    @(negedge clk);
    check("R11 no response without request", 32'(v0), 32'h0);

    // R7: data0=F0, instr7=8001, instr2=A5
    alloc(3'd0, 1'b0); check("R7 master0 data",  32'(m0), 32'h00F0);
    alloc(3'd7, 1'b1); check("R7 master7 instr", 32'(m0), 32'h8001);
    alloc(3'd2, 1'b1); check("R7 master2 instr", 32'(m0), 32'h00A5);
    alloc(3'd2, 1'b0); check("R7 master2 data",  32'(m0), 32'h0000);
    alloc(3'd7, 1'b0); check("R7 master7 data",  32'(m0), 32'h0000);

    // R6 / R10 on 8-way single-pair instance
    bus(1'b1, 1'b0, 12'h904, 32'h0000_FF03);
    alloc(3'd0, 1'b1); check("R2 u0 instr0", 32'(m0), 32'hFF03);
    alloc(3'd5, 1'b1); check("R10 u1 master ignored", 32'(m1), 32'h0003);
    check("R7 u0 master5 instr", 32'(m0), 32'h0);
    alloc(3'd6, 1'b0); check("R10 R6 u1 data0 8 ways", 32'(m1), 32'h00F0);
    bus(1'b0, 1'b0, 12'h904, 32'h0);
    check("R6 u1 upper ways read zero", d1, 32'h0003);
    bus(1'b0, 1'b0, 12'h93C, 32'h0);
    check("R10 u1 absent entry reads zero", d1, 32'h0);
    check("R10 u1 absent entry okay", 32'(r1), 32'h0);
    check("R2 u0 instr7 still set", d0, 32'h8001);

    // R1: reset mid-run clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    alloc(3'd7, 1'b1); check("R1 mask cleared by reset", 32'(m0), 32'h0);
    bus(1'b0, 1'b0, 12'h900, 32'h0);
    check("R1 data0 cleared by reset", d0, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule